// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

An 8-bit up counter, fed by a free-running prescaler, serves either as a periodic interval source or as a watchdog. A control/status register holds an overflow flag, a mode bit, an enable bit and a 3-bit clock select. The clock select picks one of eight prescaler taps. In interval mode a counter overflow sets the flag and raises a level interrupt request. In watchdog mode the same overflow instead drives an active-low output pulse of fixed length. The counter wraps and keeps running in both modes.

Software reaches the control register at address 0 and the counter at address 1 over a single-cycle synchronous bus. A write is 16 bits wide, and its upper byte must carry a key that matches the target register. Any other write is dropped. Software services the watchdog by reloading the counter with a keyed write. The flag clears only through a handshake: a read that returns it as 1, followed later by a keyed write of 0 to it.

Top module: `dual_mode_timer`

## Requirements
- R1: While enabled, the counter rises by one on each prescaler tick, steps from 0xFF to 0x00 on the tick after 0xFF, and that step is the overflow event.
- R2: Clock select value c gives one tick every D system clocks, with D = 2, 64, 128, 256, 512, 1024, 4096, 8192 for c = 0 to 7.
- R3: With the enable bit at 0, the counter reads 0x00 and holds there, and keyed counter writes have no effect. The prescaler is also held at zero, so the first counter step after enabling arrives exactly D clocks after the enabling write.
- R4: In interval mode (mode bit 0), an overflow sets the flag. `irq_interval` is high exactly while the flag is 1 and the mode bit is 0.
- R5: In watchdog mode (mode bit 1), an overflow drives `wdt_ovf_n` low for 128 clocks, starting at the overflow edge, and leaves the flag unchanged. The counter keeps counting from 0x00.
- R6: The flag clears only when a keyed control write with bit 7 = 0 follows a bus read of address 0 that returned the flag as 1. A write of 1 to bit 7, or a write of 0 with no such read before it, leaves the flag set.
- R7: Address 0 reads as {flag[7], mode[6], enable[5], 1[4], 1[3], clock select[2:0]}, and its value after reset is 0x18. Address 1 reads as the counter. Read data follows `bus_addr` combinationally.
- R8: A control write takes effect only when bus_wdata[15:8] = 0xA5. It then loads mode from bit 6, enable from bit 5 and clock select from bits 2:0.
- R9: A counter write takes effect only when bus_wdata[15:8] = 0x5A. It then loads bus_wdata[7:0] into the counter, and that load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, used for the flag-clear handshake |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 16 | Key in [15:8], data in [7:0] |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_interval | output | 1 | Interval interrupt request level |
| wdt_ovf_n | output | 1 | Active-low watchdog overflow pulse |

## Verification
The bench builds the block with its default parameters: both keys at their defaults, an 8-bit counter, a 13-bit prescaler and a 128-clock pulse. All eight taps are timed from a fresh enable, each measured to the exact edge of the first counter step. The /2 tap makes full 256-tick overflows in both modes cheap, so the bench can locate the exact start and end of the 128-clock watchdog pulse. The slowest tap gives a window free of ticks, and random keyed and unkeyed counter loads are read back inside that window.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int CNT_W   = 8;
    localparam int PRESC_W = 13;
    localparam int CKS_W   = 3;

    typedef struct packed {
        logic             flag;
        logic             mode;   // 1 = watchdog
        logic             en;
        logic [CKS_W-1:0] cks;
    } ctrl_t;

    // log2 of the divide ratio for each clock select value
    function automatic int unsigned tap_log2(input logic [CKS_W-1:0] c);
        case (c)
            3'd0:    tap_log2 = 1;
            3'd1:    tap_log2 = 6;
            3'd2:    tap_log2 = 7;
            3'd3:    tap_log2 = 8;
            3'd4:    tap_log2 = 9;
            3'd5:    tap_log2 = 10;
            3'd6:    tap_log2 = 12;
            default: tap_log2 = 13;
        endcase
    endfunction

    function automatic logic [PRESC_W-1:0] tap_mask(input logic [CKS_W-1:0] c);
        logic [PRESC_W:0] one_hot;
        one_hot  = '0;
        one_hot[tap_log2(c)] = 1'b1;
        tap_mask = PRESC_W'(one_hot - 1'b1);
    endfunction

    function automatic logic [7:0] pack_status(input ctrl_t r);
        pack_status = {r.flag, r.mode, r.en, 2'b11, r.cks};
    endfunction

endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler
    import dmt_pkg::*;
#(
    parameter int PW = PRESC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    logic [PW-1:0] div_q;
    logic [PW-1:0] mask;

    always_comb begin
        mask = PW'(tap_mask(cks));
        tick = run && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    assign ovf = run && tick && !load && (cnt == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (tick)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dmt_ctrl_reg.sv
module dmt_ctrl_reg
    import dmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ok,
    input  logic             rd_ctrl,
    input  logic [2:0]       d_hi,   // flag, mode, enable
    input  logic [CKS_W-1:0] d_cks,
    input  logic             ovf,
    output ctrl_t            ctrl
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            armed_q <= 1'b0;
        end else begin
            if (rd_ctrl && ctrl.flag) armed_q <= 1'b1;
            if (wr_ok) begin
                ctrl.mode <= d_hi[1];
                ctrl.en   <= d_hi[0];
                ctrl.cks  <= d_cks;
            end
            if (ovf && !ctrl.mode) begin
                ctrl.flag <= 1'b1;
            end else if (wr_ok && !d_hi[2] && armed_q) begin
                ctrl.flag <= 1'b0;
                armed_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmt_pulse.sv
module dmt_pulse #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic out_n
);
    localparam int PCW = $clog2(LEN + 1);
    logic [PCW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)               left_q <= '0;
        else if (fire)         left_q <= PCW'(LEN);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign out_n = (left_q == '0);
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import dmt_pkg::*;
#(
    parameter logic [7:0] KEY_CTRL  = 8'hA5,
    parameter logic [7:0] KEY_CNT   = 8'h5A,
    parameter int         PULSE_LEN = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_interval,
    output logic        wdt_ovf_n
);
    ctrl_t            ctrl_q;
    logic             tick;
    logic             ovf_evt;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ctrl_ok;
    logic             wr_cnt_ok;
    logic             rd_ctrl;

    assign wr_ctrl_ok = bus_wr && !bus_addr && (bus_wdata[15:8] == KEY_CTRL);
    assign wr_cnt_ok  = bus_wr &&  bus_addr && (bus_wdata[15:8] == KEY_CNT);
    assign rd_ctrl    = bus_rd && !bus_addr;

    dmt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ctrl_ok),
        .rd_ctrl (rd_ctrl),
        .d_hi    (bus_wdata[7:5]),
        .d_cks   (bus_wdata[2:0]),
        .ovf     (ovf_evt),
        .ctrl    (ctrl_q)
    );

    dmt_prescaler #(.PW(PRESC_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.en),
        .cks  (ctrl_q.cks),
        .tick (tick)
    );

    dmt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.en),
        .tick     (tick),
        .load     (wr_cnt_ok),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt_q),
        .ovf      (ovf_evt)
    );

    dmt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (ovf_evt && ctrl_q.mode),
        .out_n (wdt_ovf_n)
    );

    always_comb begin
        bus_rdata    = bus_addr ? 8'(cnt_q) : pack_status(ctrl_q);
        irq_interval = ctrl_q.flag && !ctrl_q.mode;
    end
endmodule

// File: rtl/dual_mode_timer_chk.sv
module dual_mode_timer_chk #(
    parameter logic [7:0] KEY_CTRL = 8'hA5,
    parameter logic [7:0] KEY_CNT  = 8'h5A
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] key_hi,
    input logic       wbit7,
    input logic       en,
    input logic       mode,
    input logic       flag,
    input logic [7:0] cnt,
    input logic       tick,
    input logic       ovf,
    input logic       wdt_ovf_n,
    input logic       irq
);
    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !(bus_wr && bus_addr && key_hi == KEY_CNT)) |=> $stable(cnt));

    assert_cnt_off_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == 8'h00));

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(ovf && !mode));

    assert_irq_flag_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    assert_wdo_fire_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_ovf_n) |-> $past(ovf && mode));

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(bus_wr && !bus_addr && key_hi == KEY_CTRL && !wbit7));

    assert_ctrl_key_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && key_hi != KEY_CTRL) |=> ($stable(en) && $stable(mode)));
endmodule

bind dual_mode_timer dual_mode_timer_chk #(.KEY_CTRL(KEY_CTRL), .KEY_CNT(KEY_CNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .key_hi    (bus_wdata[15:8]),
    .wbit7     (bus_wdata[7]),
    .en        (ctrl_q.en),
    .mode      (ctrl_q.mode),
    .flag      (ctrl_q.flag),
    .cnt       (cnt_q),
    .tick      (tick),
    .ovf       (ovf_evt),
    .wdt_ovf_n (wdt_ovf_n),
    .irq       (irq_interval)
);

// File: tb/test_dual_mode_timer.sv
module test_dual_mode_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_interval;
    logic        wdt_ovf_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_mode_timer i_dual_mode_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_interval(irq_interval), .wdt_ovf_n(wdt_ovf_n)
    );

    function automatic int divisor(input int c);
        int t[8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};
        return t[c];
    endfunction

    function automatic logic [7:0] exp_status(input bit f, input bit m, input bit e, input int c);
        return {f, m, e, 2'b11, 3'(c)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 190000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_cnt;
        bit m;
        int c;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state R7
        peek(1'b0, v); check("R7 reset status", v, 8'h18);
        peek(1'b1, v); check("R7 reset counter", v, 0);
        check("R4 reset irq", irq_interval, 0);
        check("R5 reset wdt", wdt_ovf_n, 1);

        // R2/R3 each tap timed from a fresh enable
        for (int k = 0; k < 8; k++) begin
            bus_write(1'b0, {8'hA5, 8'h20 | 8'(k)});
            repeat (divisor(k) - 1) @(negedge clk);
            peek(1'b1, v); check($sformatf("R2 R3 tap %0d before", k), v, 0);
            @(negedge clk);
            peek(1'b1, v); check($sformatf("R2 R1 tap %0d step", k), v, 1);
            peek(1'b0, v); check("R7 status enabled", v, exp_status(0, 0, 1, k));
            bus_write(1'b0, {8'hA5, 8'h00 | 8'(k)});
        end

        // R3 disabled counter ignores loads
        bus_write(1'b0, {8'hA5, 8'h27});
        bus_write(1'b1, {8'h5A, 8'h80});
        peek(1'b1, v); check("R9 load", v, 8'h80);
        bus_write(1'b0, {8'hA5, 8'h07});
        repeat (50) @(negedge clk);
        peek(1'b1, v); check("R3 disabled zero", v, 0);
        bus_write(1'b1, {8'h5A, 8'h33});
        peek(1'b1, v); check("R3 load ignored when off", v, 0);

        // R4 interval overflow, R6 clear handshake
        bus_write(1'b0, {8'hA5, 8'h20});
        repeat (511) @(negedge clk);
        peek(1'b0, v); check("R4 no flag before overflow", v, 8'h38);
        check("R4 irq low", irq_interval, 0);
        @(negedge clk);
        peek(1'b0, v); check("R4 R1 flag after overflow", v, 8'hB8);
        check("R4 irq high", irq_interval, 1);
        peek(1'b1, v); check("R1 wrap to zero", v, 0);
        bus_write(1'b0, {8'hA5, 8'h60});
        check("R4 irq low in watchdog mode", irq_interval, 0);
        peek(1'b0, v); check("R4 flag kept mode 1", v, 8'hF8);
        bus_write(1'b0, {8'hA5, 8'hA0});
        peek(1'b0, v); check("R6 write one no effect", v, 8'hB8);
        check("R4 irq back", irq_interval, 1);
        bus_write(1'b0, {8'hA5, 8'h20});
        peek(1'b0, v); check("R6 zero without read", v, 8'hB8);
        bus_read(1'b0, v); check("R6 read sees flag", v, 8'hB8);
        bus_write(1'b0, {8'h11, 8'h20});
        peek(1'b0, v); check("R8 R6 unkeyed clear ignored", v, 8'hB8);
        bus_write(1'b0, {8'hA5, 8'h20});
        peek(1'b0, v); check("R6 flag cleared", v, 8'h38);
        check("R6 irq cleared", irq_interval, 0);
        bus_write(1'b0, {8'hA5, 8'h00});

        // R5 watchdog pulse
        bus_write(1'b0, {8'hA5, 8'h60});
        repeat (511) @(negedge clk);
        check("R5 wdt high before", wdt_ovf_n, 1);
        @(negedge clk);
        check("R5 wdt low at overflow", wdt_ovf_n, 0);
        peek(1'b0, v); check("R5 flag untouched", v, 8'h78);
        check("R5 no irq", irq_interval, 0);
        repeat (127) @(negedge clk);
        check("R5 wdt still low", wdt_ovf_n, 0);
        @(negedge clk);
        check("R5 wdt released", wdt_ovf_n, 1);
        peek(1'b1, v); check("R5 counter kept counting", v, 64);
        bus_write(1'b0, {8'hA5, 8'h00});

        // R9 random keyed / unkeyed counter loads on slowest tap
        bus_write(1'b0, {8'hA5, 8'h27});
        exp_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            logic [7:0] d = 8'($urandom);
            logic [7:0] key = 8'($urandom);
            if ($urandom % 2 == 0) key = 8'h5A;
            else if (key == 8'h5A) key = 8'h5B;
            if (key == 8'h5A) exp_cnt = d;
            bus_write(1'b1, {key, d});
            peek(1'b1, v); check("R9 random load", v, exp_cnt);
        end
        bus_write(1'b0, {8'hA5, 8'h00});

        // R8 random control writes, enable kept off
        m = 0; c = 0;
        for (int i = 0; i < 30; i++) begin
            logic [7:0] d = 8'($urandom) & 8'hDF;
            logic [7:0] key = 8'($urandom);
            if ($urandom % 2 == 0) key = 8'hA5;
            else if (key == 8'hA5) key = 8'hA4;
            if (key == 8'hA5) begin m = d[6]; c = int'(d[2:0]); end
            bus_write(1'b0, {key, d});
            peek(1'b0, v); check("R8 R7 random control", v, exp_status(0, m, 0, c));
        end
        finish_run();
    end
endmodule